// File: doc/BRIEF.md
# Byte-Merging Store Queue

This block is a short in-order queue placed between a processor's store port and a data memory. That memory can only be written a whole 32-bit word at a time, because its check bits cover the full word. Each incoming store carries a byte address, write data and a size code (byte, halfword or word). The store is steered onto its byte lanes and then held in a slot. A slot records one aligned word address, 32 data bits and a 4-bit mask of the lanes that have been written.

A narrow store can join the newest slot when both target the same aligned word, as long as that slot is not the one currently offered to memory. Repeated narrow stores can therefore build up a complete word. A word with all four lanes is marked full on the drain side and can be written directly. A slot with fewer lanes is flagged partial, so the downstream memory knows it must read and merge before writing. Slots leave in arrival order over a valid/ready drain port. A slot is released only on the handshake cycle. When every slot is taken and the store cannot merge, the store port stalls.

Top module: `stbuf_coalesce`

## Requirements
- R1: After reset the queue is empty: `dr_valid` is 0 and `st_ready` is 1.
- R2: Size code 0 (byte) writes lane `st_addr[1:0]` with `st_data[7:0]`. Code 1 (halfword) writes lanes 1..0 when `st_addr[1]`=0 and lanes 3..2 when `st_addr[1]`=1, with `st_data[15:0]` (low byte in the lower lane), and ignores `st_addr[0]`. Codes 2 and 3 (word) write all lanes with `st_data` and ignore `st_addr[1:0]`. Lane n is `dr_data[8n+7:8n]` and `dr_mask[n]`. Lanes never written in a slot read as zero.
- R3: A store joins the newest slot when `st_addr[31:2]` matches that slot's word address and at least two slots are occupied. No new slot is taken, and the slot's mask becomes the OR of the old and new lanes.
- R4: When a joined store writes a lane that is already valid, the newer byte replaces the older one.
- R5: The slot offered on the drain port never absorbs a store. With exactly one slot occupied, a store to that slot's word takes a new slot.
- R6: A store whose word matches only an older, non-newest slot takes a new slot.
- R7: The drain port always offers the oldest slot (`dr_addr` = word address, i.e. byte address bits 31:2). That slot is removed only in a cycle where `dr_valid` and `dr_ready` are both high. Its outputs stay unchanged while it waits.
- R8: `dr_full` is 1 exactly when the offered mask is 4'b1111, and 0 for a partial slot.
- R9: With all 4 slots occupied, `st_ready` is 0 for a store that cannot join, even in a cycle where a slot drains. Such a store is not taken.
- R10: With all 4 slots occupied, a store that can join the newest slot is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Byte address of store |
| st_data | input | 32 | Store data, right-aligned |
| st_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| dr_valid | output | 1 | Oldest slot offered to memory |
| dr_ready | input | 1 | Memory takes the offered slot |
| dr_addr | output | 30 | Word address of offered slot |
| dr_data | output | 32 | Merged slot data |
| dr_mask | output | 4 | Valid byte lanes of offered slot |
| dr_full | output | 1 | Whole word present, no read needed |

## Verification
A store being accepted (merged or newly allocated) and the oldest slot draining can happen in the same cycle. The interesting cases are where the two interact. With one slot present, a same-word store must allocate while the head leaves. With two slots, a merge into the newest must survive the head being popped. With a full queue, a drain must not open the store port in that same cycle. The bench provokes these by running random drain-ready patterns against stores drawn from a pool of two or three words. It also runs a phase with drain always ready and stores every cycle. A behavioural queue model predicts `st_ready` and every drain output each cycle, and the bench compares the two.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
    localparam int LANES  = 4;
    localparam int WORD_W = 8 * LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD3 = 2'd3
    } st_size_e;
endpackage

// File: rtl/stbuf_lane_place.sv
module stbuf_lane_place
    import stbuf_pkg::*;
(
    input  logic [1:0]              addr_lo,
    input  logic [1:0]              size,
    input  logic [WORD_W-1:0]       data_in,
    output logic [LANES-1:0]        lane_en,
    output logic [WORD_W-1:0]       lane_data
);
    // first lane written and its source byte per lane
    logic [1:0] first_lane;

    always_comb begin
        unique case (st_size_e'(size))
            SZ_BYTE: first_lane = addr_lo;
            SZ_HALF: first_lane = {addr_lo[1], 1'b0};
            default: first_lane = 2'd0;
        endcase
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [1:0] rel;
        logic       hit;
        always_comb begin
            rel = 2'(ln) - first_lane;
            unique case (st_size_e'(size))
                SZ_BYTE: hit = (2'(ln) == first_lane);
                SZ_HALF: hit = (2'(ln) >> 1) == (first_lane >> 1);
                default: hit = 1'b1;
            endcase
        end
        assign lane_en[ln]            = hit;
        assign lane_data[8*ln +: 8]   = hit ? data_in[8*rel +: 8] : 8'h00;
    end
endmodule

// File: rtl/stbuf_lane_merge.sv
module stbuf_lane_merge
    import stbuf_pkg::*;
(
    input  logic [WORD_W-1:0]  old_data,
    input  logic [WORD_W-1:0]  new_data,
    input  logic [LANES-1:0]   new_en,
    output logic [WORD_W-1:0]  merged
);
    for (genvar ln = 0; ln < LANES; ln++) begin : g_mrg
        assign merged[8*ln +: 8] = new_en[ln] ? new_data[8*ln +: 8] : old_data[8*ln +: 8];
    end
endmodule

// File: rtl/stbuf_coalesce.sv
module stbuf_coalesce
    import stbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [WORD_W-1:0]    st_data,
    input  logic [1:0]           st_size,
    output logic                 dr_valid,
    input  logic                 dr_ready,
    output logic [ADDR_W-3:0]    dr_addr,
    output logic [WORD_W-1:0]    dr_data,
    output logic [LANES-1:0]     dr_mask,
    output logic                 dr_full
);
    localparam int WA_W  = ADDR_W - 2;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] TWO_CNT  = CNT_W'(2);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WA_W-1:0]   waddr;
        logic [DEPTH-1:0][WORD_W-1:0] data;
        logic [DEPTH-1:0][LANES-1:0]  mask;
        logic [PTR_W-1:0]             head;
        logic [CNT_W-1:0]             count;
    } state_t;

    state_t q, d;

    logic [LANES-1:0]  place_en;
    logic [WORD_W-1:0] place_data;
    logic [WORD_W-1:0] merged_word;
    logic [PTR_W-1:0]  young_idx;
    logic [PTR_W-1:0]  tail_idx;
    logic              merge_hit;
    logic              accept;
    logic              drain;

    stbuf_lane_place u_place (
        .addr_lo   (st_addr[1:0]),
        .size      (st_size),
        .data_in   (st_data),
        .lane_en   (place_en),
        .lane_data (place_data)
    );

    stbuf_lane_merge u_merge (
        .old_data (q.data[young_idx]),
        .new_data (place_data),
        .new_en   (place_en),
        .merged   (merged_word)
    );

    always_comb begin
        young_idx = PTR_W'((int'(q.head) + int'(q.count) + DEPTH - 1) % DEPTH);
        tail_idx  = PTR_W'((int'(q.head) + int'(q.count)) % DEPTH);
        // the head is always on offer, so merging needs an older slot in front
        merge_hit = (q.count >= TWO_CNT) && (q.waddr[young_idx] == st_addr[ADDR_W-1:2]);
        st_ready  = merge_hit || (q.count < FULL_CNT);
        accept    = st_valid && st_ready;
        drain     = (q.count != '0) && dr_ready;

        d = q;
        if (accept && merge_hit) begin
            d.data[young_idx] = merged_word;
            d.mask[young_idx] = q.mask[young_idx] | place_en;
        end else if (accept) begin
            d.waddr[tail_idx] = st_addr[ADDR_W-1:2];
            d.data[tail_idx]  = place_data;
            d.mask[tail_idx]  = place_en;
        end
        if (drain) begin
            d.head = (q.head == LAST_PTR) ? '0 : q.head + 1'b1;
        end
        d.count = q.count + CNT_W'(accept && !merge_hit) - CNT_W'(drain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dr_valid = (q.count != '0);
    assign dr_addr  = q.waddr[q.head];
    assign dr_data  = q.data[q.head];
    assign dr_mask  = q.mask[q.head];
    assign dr_full  = &q.mask[q.head];

    // R7: the offered slot is frozen while memory back-pressures
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_data) && $stable(dr_mask));

    // R2: an offered slot always carries at least one lane
    a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> dr_mask != '0);

    // R9: the store port only stalls when every slot is in use
    a_r9_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |-> q.count == FULL_CNT);

    // R3: a merged store takes no slot
    a_r3_merge_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        accept && merge_hit |=> q.count == $past(q.count) - CNT_W'($past(drain)));

    // R1: an empty queue offers nothing
    a_r1_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.count == '0 |-> !dr_valid && st_ready);
endmodule

// File: tb/tb_stbuf_coalesce.sv
module tb_stbuf_coalesce;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [1:0]  st_size = '0;
    logic        dr_valid;
    logic        dr_ready = 1'b0;
    logic [29:0] dr_addr;
    logic [31:0] dr_data;
    logic [3:0]  dr_mask;
    logic        dr_full;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stbuf_coalesce dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_size(st_size),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
        .dr_data(dr_data), .dr_mask(dr_mask), .dr_full(dr_full)
    );

    typedef struct {
        bit [29:0] wa;
        bit [31:0] data;
        bit [3:0]  mask;
    } entry_t;

    entry_t model[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural lane steering (R2)
    task automatic place(input bit [31:0] a, input bit [31:0] dat, input bit [1:0] sz,
                         output bit [31:0] pd, output bit [3:0] pm);
        int first, n;
        pd = '0; pm = '0;
        if (sz == 2'd0)      begin first = int'(a[1:0]);   n = 1; end
        else if (sz == 2'd1) begin first = a[1] ? 2 : 0;   n = 2; end
        else                 begin first = 0;              n = 4; end
        for (int i = 0; i < n; i++) begin
            pm[first+i] = 1'b1;
            pd[(first+i)*8 +: 8] = dat[i*8 +: 8];
        end
    endtask

    // one cycle: drive at negedge, compare, then advance model at posedge
    task automatic step(input bit sv, input bit [31:0] a, input bit [31:0] dat,
                        input bit [1:0] sz, input bit rdy);
        bit hit, exp_rdy, exp_v, acc, drn;
        bit [31:0] pd; bit [3:0] pm;
        st_valid = sv; st_addr = a; st_data = dat; st_size = sz; dr_ready = rdy;
        #1;
        hit     = (model.size() >= 2) && (model[$].wa == a[31:2]);   // R3 R5 R6
        exp_rdy = hit || (model.size() < 4);                          // R9 R10
        exp_v   = (model.size() != 0);
        chk(st_ready == exp_rdy, "R9/R10 st_ready", 32'(st_ready), 32'(exp_rdy));
        chk(dr_valid == exp_v, "R7 dr_valid", 32'(dr_valid), 32'(exp_v));
        if (exp_v) begin
            chk(dr_addr == model[0].wa, "R7 dr_addr", 32'(dr_addr), 32'(model[0].wa));
            chk(dr_mask == model[0].mask, "R2/R3/R5/R6 dr_mask", 32'(dr_mask), 32'(model[0].mask));
            chk(dr_data == model[0].data, "R2/R4 dr_data", dr_data, model[0].data);
            chk(dr_full == (model[0].mask == 4'hF), "R8 dr_full", 32'(dr_full),
                32'(model[0].mask == 4'hF));
        end
        acc = sv && exp_rdy;
        drn = exp_v && rdy;
        place(a, dat, sz, pd, pm);
        @(posedge clk);
        if (drn) void'(model.pop_front());
        if (acc && hit) begin
            for (int ln = 0; ln < 4; ln++)
                if (pm[ln]) model[$].data[ln*8 +: 8] = pd[ln*8 +: 8];
            model[$].mask = model[$].mask | pm;
        end else if (acc) begin
            entry_t e;
            e.wa = a[31:2]; e.data = pd; e.mask = pm;
            model.push_back(e);
        end
        @(negedge clk);
    endtask

    function automatic bit [31:0] pool_addr(input int words);
        return 32'h4000_0100 + 32'(($urandom % words) * 4) + 32'($urandom % 4);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(dr_valid == 1'b0, "R1 dr_valid after reset", 32'(dr_valid), 32'h0);
        chk(st_ready == 1'b1, "R1 st_ready after reset", 32'(st_ready), 32'h1);
        rst_n = 1'b1;

        // drain blocked: fills queue, merges into newest when full (R10), stalls (R9)
        for (int c = 0; c < 40; c++)
            step(1'b1, pool_addr(2), $urandom, 2'($urandom % 4), 1'b0);
        // R5/R4: single slot on offer, same-word bytes while it drains
        for (int c = 0; c < 20; c++) step(1'b0, '0, '0, '0, 1'b1);
        for (int c = 0; c < 200; c++)
            step(1'b1, 32'h4000_0200 + 32'(c % 4), $urandom, 2'd0, 1'b1);
        // mixed traffic over three words, random back-pressure (R3 R6 R7 R8)
        for (int c = 0; c < 3000; c++)
            step(($urandom % 4) != 0, pool_addr(3), $urandom, 2'($urandom % 4),
                 ($urandom % 3) == 0);
        // bursts of narrow stores against slow drain
        for (int c = 0; c < 2000; c++)
            step(1'b1, pool_addr(2), $urandom, 2'($urandom % 2), ($urandom % 5) == 0);
        // scattered addresses
        for (int c = 0; c < 1000; c++)
            step($urandom % 2 == 0, $urandom, $urandom, 2'($urandom % 4), $urandom % 2 == 0);
        // drain out
        for (int c = 0; c < 10; c++) step(1'b0, '0, '0, '0, 1'b1);
        chk(dr_valid == 1'b0, "R7 queue empties", 32'(dr_valid), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule